// File: doc/BRIEF.md
# Bit-Serial Adder with Shift Registers

This block adds two unsigned words one bit per clock using two shift registers, a single full adder and one carry flip-flop. Both operands arrive on a single serial data line, least significant bit first, and always enter the second register. The full adder's sum bit always feeds the top of the first register. While the second operand is loading, the first register is still empty and the stored carry is zero, so the full adder simply passes the outgoing bits of the first operand into the first register.

A start pulse from idle clears both registers and the carry. The block then takes sixteen load clocks: eight for the augend and eight for the addend. It clears the carry again and runs eight add clocks. After the last add clock it raises a one-cycle done pulse. The first register is visible in parallel at all times, and it holds the sum once done fires. The final carry is held on a separate output as the unsigned overflow.

Top module: `bitser_add`

## Requirements
- R1: While rst_n is low at a rising edge (synchronous, active low), the block returns to idle. After that edge sum_o is 0, carry_o is 0 and done_o is 0.
- R2: A start_i high at an edge while idle clears both registers and the carry. After that edge sum_o is 0 and carry_o is 0.
- R3: ser_in_i is sampled on the 16 edges that follow the start edge. The first 8 samples are the augend and the next 8 are the addend, each least significant bit first. After the 16th of these edges sum_o equals the augend.
- R4: Eight edges after the last load edge, sum_o equals (augend + addend) mod 256.
- R5: At that point carry_o equals bit 8 of augend + addend. While idle without a start, sum_o and carry_o hold their values.
- R6: done_o is high for exactly one cycle, right after the 24th edge that follows the start edge. It is never high on two consecutive cycles.
- R7: A start_i pulse during loading or adding is ignored and does not change the result or its timing.
- R8: ser_in_i has no effect outside the 16 load edges. Bits entering the second register during the add phase are 0, so that register is empty when done fires.
- R9: A reset during a run aborts it. No done pulse follows until a new start.
- R10: Adding 0x5D and 0x9E gives sum 0xFB and carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| ser_in_i | input | 1 | Serial operand bits, LSB first |
| sum_o | output | WIDTH | Parallel view of the accumulating register |
| carry_o | output | 1 | Final carry of the last addition |
| done_o | output | 1 | One-cycle pulse when the sum is ready |

## Verification
The bench checks the load boundary: after exactly sixteen load edges the accumulating register must hold the augend. A sequencer that miscounts by one edge would leave a shifted augend there. Carry-heavy operands such as 0xFF+0x01 and 0xFF+0xFF expose a carry that was not cleared after loading or was not fed back, because either fault corrupts the high bits and the carry output. The bench pulses start in mid-run, puts noise on the serial input during the add and idle phases, and resets mid-load. A design that restarted, sampled outside the load window, or kept running after the abort would give a wrong sum, a shifted done pulse, or a done pulse nobody expected.

// File: rtl/bsa_pkg.sv
// Package: shared types for the bit-serial adder.
// Assumes: nothing beyond IEEE 1800-2017.
package bsa_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_ADD  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/bsa_shreg.sv
// Module: right-shifting register; new bits enter at the MSB, the LSB leaves.
// Assumes: clr_i has priority over shift_i; reset is synchronous, active low.
module bsa_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         ser_i,
    output logic [W-1:0] par_o,
    output logic         out_o
);
    logic [W-1:0] q;

    // Hold, clear or shift the stored word by one place toward the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            q <= '0;
        end else if (shift_i) begin
            q <= {ser_i, q[W-1:1]};
        end
    end

    assign par_o = q;
    assign out_o = q[0];
endmodule

// File: rtl/bsa_fulladd.sv
// Module: one-bit full adder.
// Assumes: purely combinational; the caller registers the carry.
module bsa_fulladd (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    // Form sum and carry of three input bits.
    always_comb begin
        s_o = a_i ^ b_i ^ c_i;
        c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end
endmodule

// File: rtl/bsa_carry.sv
// Module: carry storage flip-flop feeding the next bit pair.
// Assumes: clr_i has priority over cap_i.
module bsa_carry (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic cap_i,
    input  logic d_i,
    output logic q_o
);
    // Capture the adder carry-out, or clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            q_o <= 1'b0;
        end else if (cap_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/bsa_seq.sv
// Module: sequencer for clear, 2*W load clocks and W add clocks, then done.
// Assumes: start_i is honoured only in idle; reset is synchronous, active low.
module bsa_seq
    import bsa_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic clr_o,
    output logic shift_o,
    output logic load_o,
    output logic add_o,
    output logic carry_clr_o,
    output logic done_o
);
    localparam int LOAD_N = 2 * W;
    localparam int CW     = $clog2(LOAD_N);
    localparam logic [CW-1:0] LOAD_LAST = CW'(LOAD_N - 1);
    localparam logic [CW-1:0] ADD_LAST  = CW'(W - 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;

    // Decode phase strobes from the current state.
    always_comb begin
        clr_o       = (state == SEQ_IDLE) && start_i;
        load_o      = (state == SEQ_LOAD);
        add_o       = (state == SEQ_ADD);
        shift_o     = load_o || add_o;
        carry_clr_o = load_o && (cnt == LOAD_LAST);
    end

    // Advance the state and the phase counter, and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            cnt    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    cnt <= '0;
                    if (start_i) begin
                        state <= SEQ_LOAD;
                    end
                end
                SEQ_LOAD: begin
                    if (cnt == LOAD_LAST) begin
                        cnt   <= '0;
                        state <= SEQ_ADD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_ADD: begin
                    if (cnt == ADD_LAST) begin
                        cnt    <= '0;
                        state  <= SEQ_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SEQ_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/bitser_add.sv
// Module: top of the bit-serial adder. Both operands pass in through
// register B. The full adder's sum always refills register A.
// Assumes: operands arrive LSB first, augend before addend.
module bitser_add #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ser_in_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             done_o
);
    logic             clr, shift_en, load_ph, add_ph, carry_clr;
    logic             a_out, b_out, b_in, fa_sum, fa_cout, carry_q;
    logic [WIDTH-1:0] a_word, b_word;

    bsa_seq #(.W(WIDTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .clr_o(clr), .shift_o(shift_en), .load_o(load_ph), .add_o(add_ph),
        .carry_clr_o(carry_clr), .done_o(done_o)
    );

    // Only load clocks let the serial line into B; zeros fill it otherwise.
    always_comb b_in = load_ph & ser_in_i;

    bsa_shreg #(.W(WIDTH)) u_reg_b (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .shift_i(shift_en),
        .ser_i(b_in), .par_o(b_word), .out_o(b_out)
    );

    bsa_shreg #(.W(WIDTH)) u_reg_a (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .shift_i(shift_en),
        .ser_i(fa_sum), .par_o(a_word), .out_o(a_out)
    );

    bsa_fulladd u_fa (
        .a_i(a_out), .b_i(b_out), .c_i(carry_q), .s_o(fa_sum), .c_o(fa_cout)
    );

    bsa_carry u_carry (
        .clk(clk), .rst_n(rst_n), .clr_i(clr || carry_clr),
        .cap_i(add_ph), .d_i(fa_cout), .q_o(carry_q)
    );

    assign sum_o   = a_word;
    assign carry_o = carry_q;
endmodule

// File: rtl/bsa_chk.sv
// Module: property checker for bitser_add, attached by bind.
// Assumes: sampled on the rising edge; disabled while rst_n is low.
module bsa_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         done_o,
    input logic         carry_o,
    input logic [W-1:0] sum_o,
    input logic         load_ph,
    input logic         add_ph,
    input logic [W-1:0] b_word
);
    logic idle;
    always_comb idle = !load_ph && !add_ph;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_o == '0) && !carry_o && !done_o);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start_i) |=> (sum_o == '0) && !carry_o);

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start_i) |=> $stable(sum_o) && $stable(carry_o));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(add_ph));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ph && start_i) |=> (load_ph || add_ph));

    assert_b_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (b_word == '0));
endmodule

bind bitser_add bsa_chk #(.W(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .carry_o(carry_o), .sum_o(sum_o), .load_ph(load_ph), .add_ph(add_ph),
    .b_word(b_word)
);

// File: tb/test_bitser_add.sv
module test_bitser_add;
    typedef struct {
        logic [7:0] sum;
        logic       cout;
        longint     cyc;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       ser_in_i = 1'b0;
    logic [7:0] sum_o;
    logic       carry_o;
    logic       done_o;

    int     n_checks = 0;
    int     n_errors = 0;
    longint cyc = 0;
    logic   prev_done = 1'b0;
    exp_t   sb[$];

    bitser_add #(.WIDTH(8)) i_bitser_add (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ser_in_i(ser_in_i),
        .sum_o(sum_o), .carry_o(carry_o), .done_o(done_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Monitor: pop the scoreboard on each done pulse and compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                chk(!prev_done, "R6 done width", 1, 0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(sum_o == e.sum, "R4 sum", sum_o, e.sum);
                    chk(carry_o == e.cout, "R5 carry", carry_o, e.cout);
                    chk(cyc == e.cyc, "R6 done timing", cyc, e.cyc);
                end
            end
            prev_done = done_o;
        end else begin
            prev_done = 1'b0;
        end
    end

    // Driver: push the expected result, then clock in both operands.
    task automatic run_add(input logic [7:0] a, input logic [7:0] b,
                           input bit poke_start, input bit noise);
        exp_t   e;
        logic [8:0] full;
        @(negedge clk);
        full   = {1'b0, a} + {1'b0, b};
        e.sum  = full[7:0];
        e.cout = full[8];
        e.cyc  = cyc + 25;
        sb.push_back(e);
        start_i = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i == 0) begin
                chk(sum_o == 8'h00 && carry_o == 1'b0, "R2 start clears", {carry_o, sum_o}, 0);
            end
            start_i  = poke_start && (i == 5 || i == 12);
            ser_in_i = (i < 8) ? a[i] : b[i-8];
        end
        @(negedge clk);
        chk(sum_o == a, "R3 augend in A after load", sum_o, a);
        start_i = poke_start;
        for (int k = 0; k < 8; k++) begin
            ser_in_i = noise ? 1'($urandom) : 1'b0;
            if (k == 1) start_i = 1'b0;
            @(negedge clk);
        end
        start_i  = 1'b0;
        ser_in_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        report();
    end

    initial begin
        logic [7:0] hs;
        logic       hc;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sum_o == 0 && carry_o == 0 && done_o == 0, "R1 reset state",
            {done_o, carry_o, sum_o}, 0);

        // R10: known vector
        run_add(8'h5D, 8'h9E, 1'b0, 1'b0);
        chk(sum_o == 8'hFB && carry_o == 1'b0, "R10 known vector", {carry_o, sum_o}, 9'h0FB);

        run_add(8'hFF, 8'h01, 1'b0, 1'b0);
        // R5/R8: idle hold with serial noise
        hs = sum_o; hc = carry_o;
        for (int k = 0; k < 6; k++) begin
            ser_in_i = ~ser_in_i;
            @(negedge clk);
        end
        ser_in_i = 1'b0;
        chk(sum_o == hs && carry_o == hc, "R5 R8 idle hold", {carry_o, sum_o}, {hc, hs});

        run_add(8'h00, 8'h00, 1'b0, 1'b0);
        run_add(8'hFF, 8'hFF, 1'b0, 1'b1);
        run_add(8'h80, 8'h80, 1'b1, 1'b0);   // R7 start pokes
        run_add(8'hA5, 8'h5A, 1'b1, 1'b1);   // R7 and R8 together
        for (int t = 0; t < 20; t++) begin
            run_add(8'($urandom), 8'($urandom), t[0], t[1]);
        end

        // R9: reset mid-load aborts the run
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            ser_in_i = 1'b1;
            @(negedge clk);
        end
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sum_o == 0 && carry_o == 0 && done_o == 0, "R9 abort clears",
            {done_o, carry_o, sum_o}, 0);
        repeat (30) @(negedge clk);
        ser_in_i = 1'b0;
        chk(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
        chk(sum_o == 0, "R9 no further activity", sum_o, 0);

        run_add(8'h37, 8'hC9, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        report();
    end
endmodule